// File: doc/BRIEF.md
# Pipelined Burst Static RAM Model

This block is a synthesizable, cycle-level model of a pipelined synchronous static RAM that bursts through four-word groups. Two separate active-low address strobes start accesses: one meant for a processor, which always starts a read, and one meant for a memory controller, which starts either a read or a write. Between strobes, a step input moves the internal address to the next word of the current four-word group, wrapping inside it. When the step input is high, the address is held and the same access repeats.

Every input is sampled on the rising clock edge. A strobe edge qualifies the two chip-select inputs, which have opposite polarity. A qualified strobe captures the address. An unqualified strobe ends the burst, and the block then stays idle until the next qualified strobe. Read data is registered on the edge that performs the read, so it is presented during the following clock period. A valid flag marks it, and a drive flag models the output buffer. When the drive flag is low, the data output reads as zero, which stands for high impedance.

Top module: `burst_sram_model`

## Requirements
- R1: After reset, `dout_valid` and `dout_en` are 0 and `dout` is 0. No burst is active, so a step cycle on its own produces no output.
- R2: On an edge where either strobe is low and the chip is selected, the block captures `addr`. For a read, the word stored at that address appears on `dout` during the following period, with `dout_valid` set to 1.
- R3: An edge with `proc_strobe_n` low performs a read even when `wr_n` is low. The array is not written on that edge.
- R4: A write happens on a selected edge with `wr_n` low and `proc_strobe_n` high. Such an edge is either a controller-strobe edge or a continuation edge. The write stores `din` at the current address, and the following period shows `dout_valid` 0 and `dout_en` 0.
- R5: The chip is selected only when `sel_lo_n` is 0 and `sel_hi` is 1 on an edge where a strobe is low. A strobe edge that is not selected captures nothing and turns the output off (`dout_valid` 0, `dout_en` 0).
- R6: An edge with both strobes high and `step_n` low, during an active burst, increments the two low address bits modulo 4. The upper address bits do not change, so word 7 is followed by word 4.
- R7: An edge with both strobes high and `step_n` high, during an active burst, keeps the address and repeats the access.
- R8: After a deselecting strobe, continuation edges perform no access: there is no read output and no write, until the next selected strobe.
- R9: On a read edge with `wr_n` high, `oe_n` sampled high gives `dout_en` 0 and `dout` 0 in the following period while `dout_valid` stays 1. `oe_n` sampled low drives the data.
- R10: `oe_n` is ignored on edges where `wr_n` is low. A processor-strobe read with `wr_n` low drives its data even with `oe_n` high, and a write edge never drives, even with `oe_n` low.
- R11: The chip-select inputs are not examined on continuation edges. A step with the selects deasserted still advances and reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| proc_strobe_n | input | 1 | Processor address strobe, active low, always starts a read |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Active low: advance the burst address on a continuation edge |
| wr_n | input | 1 | Write enable, active low |
| sel_lo_n | input | 1 | Chip select, active low |
| sel_hi | input | 1 | Chip select, active high |
| oe_n | input | 1 | Output enable, active low, sampled on the clock |
| addr | input | ADDR_W | Word address captured on selected strobe edges |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, 0 when not driven |
| dout_en | output | 1 | Output buffer driving (0 models high impedance) |
| dout_valid | output | 1 | Read data from the previous edge is present |

## Verification
The bench builds the block with DATA_W=8 and ADDR_W=4. That gives sixteen words, which is four burst groups. With four groups, a wrap from word 7 back to word 4 can be told apart from a carry into word 8 or a drop to word 0, because each of those words holds a distinct known value. The narrow data word lets each test use a recognisable byte. A read after a suppressed write can then show that the array was left untouched.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  localparam int BURST_W = 2;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_t;

  function automatic logic strobe_seen(input logic p_n, input logic c_n);
    return !p_n || !c_n;
  endfunction

  function automatic logic chip_selected(input logic lo_n, input logic hi);
    return !lo_n && hi;
  endfunction

  // Output buffer may drive: OE only matters when the write line is high.
  function automatic logic drive_allowed(input logic w_n, input logic o_n);
    return !w_n || !o_n;
  endfunction

  function automatic logic [BURST_W-1:0] wrap_inc(input logic [BURST_W-1:0] low);
    return low + 1'b1;
  endfunction

endpackage

// File: rtl/bsr_seq_ctl.sv
module bsr_seq_ctl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              proc_strobe_n,
  input  logic              ctrl_strobe_n,
  input  logic              step_n,
  input  logic              wr_n,
  input  logic              sel_lo_n,
  input  logic              sel_hi,
  input  logic [ADDR_W-1:0] addr,
  output acc_t              acc,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              burst_live,
  output logic              ev_capture,
  output logic              ev_deselect,
  output logic              ev_continue
);

  logic strobe;
  logic [ADDR_W-1:0] stepped;

  assign strobe      = strobe_seen(proc_strobe_n, ctrl_strobe_n);
  assign ev_capture  = strobe && chip_selected(sel_lo_n, sel_hi);
  assign ev_deselect = strobe && !chip_selected(sel_lo_n, sel_hi);
  assign ev_continue = !strobe && burst_live;

  assign stepped = {cur_addr[ADDR_W-1:BURST_W], wrap_inc(cur_addr[BURST_W-1:0])};

  always_comb begin
    if (ev_capture)
      eff_addr = addr;
    else if (ev_continue && !step_n)
      eff_addr = stepped;
    else
      eff_addr = cur_addr;
  end

  always_comb begin
    if (!(ev_capture || ev_continue))
      acc = ACC_NONE;
    else if (!wr_n && proc_strobe_n)
      acc = ACC_WRITE;
    else
      acc = ACC_READ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      burst_live <= 1'b0;
      cur_addr   <= '0;
    end else begin
      if (ev_capture)
        burst_live <= 1'b1;
      else if (ev_deselect)
        burst_live <= 1'b0;
      if (ev_capture || ev_continue)
        cur_addr <= eff_addr;
    end
  end

endmodule

// File: rtl/bsr_store.sv
module bsr_store #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] a,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      cells[a] <= wdata;
    if (re)
      rdata <= cells[a];
  end

endmodule

// File: rtl/bsr_out_stage.sv
module bsr_out_stage #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_evt,
  input  logic              drive_ok,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              dout_valid
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout_valid <= 1'b0;
      dout_en    <= 1'b0;
    end else begin
      dout_valid <= rd_evt;
      dout_en    <= rd_evt && drive_ok;
    end
  end

  assign dout = dout_en ? rdata : '0;

endmodule

// File: rtl/burst_sram_model.sv
module burst_sram_model
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              proc_strobe_n,
  input  logic              ctrl_strobe_n,
  input  logic              step_n,
  input  logic              wr_n,
  input  logic              sel_lo_n,
  input  logic              sel_hi,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              dout_valid
);

  acc_t              acc;
  logic [ADDR_W-1:0] eff_addr;
  logic [ADDR_W-1:0] cur_addr;
  logic              burst_live;
  logic              ev_capture;
  logic              ev_deselect;
  logic              ev_continue;
  logic              ev_write;
  logic              ev_read;
  logic [DATA_W-1:0] rdata;

  assign ev_write = (acc == ACC_WRITE);
  assign ev_read  = (acc == ACC_READ);

  bsr_seq_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
    .step_n(step_n), .wr_n(wr_n), .sel_lo_n(sel_lo_n), .sel_hi(sel_hi),
    .addr(addr), .acc(acc), .eff_addr(eff_addr), .cur_addr(cur_addr),
    .burst_live(burst_live), .ev_capture(ev_capture),
    .ev_deselect(ev_deselect), .ev_continue(ev_continue)
  );

  bsr_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .we(ev_write), .re(ev_read), .a(eff_addr),
    .wdata(din), .rdata(rdata)
  );

  bsr_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .rd_evt(ev_read),
    .drive_ok(drive_allowed(wr_n, oe_n)), .rdata(rdata),
    .dout(dout), .dout_en(dout_en), .dout_valid(dout_valid)
  );

endmodule

// File: rtl/burst_sram_model_checker.sv
module burst_sram_model_checker #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              proc_strobe_n,
  input logic              step_n,
  input logic              ev_capture,
  input logic              ev_deselect,
  input logic              ev_continue,
  input logic              ev_write,
  input logic              burst_live,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              dout_en,
  input logic              dout_valid
);

  // R3: processor strobe on a selected edge yields read data next period
  a_r3_proc_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_capture && !proc_strobe_n) |=> dout_valid);

  // R4: a write edge leaves the output idle
  a_r4_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ev_write |=> (!dout_valid && !dout_en));

  // R5: unselected strobe turns the output off and ends the burst
  a_r5_deselect_off: assert property (@(posedge clk) disable iff (!rst_n)
    ev_deselect |=> (!dout_valid && !dout_en && !burst_live));

  // R8: no burst and no strobe means no access
  a_r8_idle_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_capture && !ev_deselect && !burst_live) |=> !dout_valid);

  // R6: step wraps inside the low two bits
  a_r6_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_continue && !step_n) |=>
      (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1) &&
      (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])));

  // R7: hold keeps the address
  a_r7_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_continue && step_n) |=> $stable(cur_addr));

  // R9: the buffer drives only valid data
  a_r9_drive_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> dout_valid);

endmodule

bind burst_sram_model burst_sram_model_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .proc_strobe_n(proc_strobe_n), .step_n(step_n),
  .ev_capture(ev_capture), .ev_deselect(ev_deselect),
  .ev_continue(ev_continue), .ev_write(ev_write), .burst_live(burst_live),
  .cur_addr(cur_addr), .dout_en(dout_en), .dout_valid(dout_valid)
);

// File: tb/burst_sram_model_bench.sv
`timescale 1ns/1ps
module burst_sram_model_bench;

  localparam int AW = 4;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ps_n = 1'b1, cs_n = 1'b1, st_n = 1'b1, w_n = 1'b1;
  logic lo_n = 1'b1, hi = 1'b0, o_n = 1'b1;
  logic [AW-1:0] a = '0;
  logic [DW-1:0] d = '0;
  logic [DW-1:0] dout;
  logic dout_en, dout_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  burst_sram_model #(.ADDR_W(AW), .DATA_W(DW)) u_burst_sram_model (
    .clk(clk), .rst_n(rst_n), .proc_strobe_n(ps_n), .ctrl_strobe_n(cs_n),
    .step_n(st_n), .wr_n(w_n), .sel_lo_n(lo_n), .sel_hi(hi), .oe_n(o_n),
    .addr(a), .din(d), .dout(dout), .dout_en(dout_en), .dout_valid(dout_valid)
  );

  // Drive one edge's inputs, then sample just after that edge.
  task automatic edge_in(input logic p, input logic c, input logic s,
                         input logic w, input logic l, input logic h,
                         input logic o, input logic [AW-1:0] ad,
                         input logic [DW-1:0] dd);
    ps_n = p; cs_n = c; st_n = s; w_n = w; lo_n = l; hi = h; o_n = o;
    a = ad; d = dd;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string tag, input logic v, input logic e,
                            input logic [DW-1:0] q);
    checks++;
    if (dout_valid !== v || dout_en !== e || dout !== q) begin
      errors++;
      $display("FAIL %s: valid/en/dout = %b/%b/%h, expected %b/%b/%h",
               tag, dout_valid, dout_en, dout, v, e, q);
    end
  endtask

  // Selected controller-strobe edges
  task automatic ctrl_write(input logic [AW-1:0] ad, input logic [DW-1:0] dd);
    edge_in(1, 0, 1, 0, 0, 1, 1, ad, dd);
  endtask
  task automatic ctrl_read(input logic [AW-1:0] ad);
    edge_in(1, 0, 1, 1, 0, 1, 0, ad, '0);
  endtask
  task automatic idle_edge();
    edge_in(1, 1, 1, 1, 1, 0, 1, '0, '0);
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    expect_out("R1 reset outputs", 0, 0, '0);
    rst_n = 1;
    edge_in(1, 1, 0, 1, 0, 1, 0, '0, '0);
    expect_out("R1 step without burst", 0, 0, '0);
  endtask

  task automatic t_fill();
    ctrl_write(4'h0, 8'hEE);
    ctrl_write(4'h8, 8'h55);
    ctrl_write(4'h9, 8'h66);
    ctrl_write(4'hC, 8'h31);
    ctrl_write(4'hD, 8'h32);
    ctrl_write(4'h4, 8'hA0);
    expect_out("R4 write edge quiet", 0, 0, '0);
    edge_in(1, 1, 0, 0, 1, 0, 0, '0, 8'hA1);
    expect_out("R4 burst write with oe low R10", 0, 0, '0);
    edge_in(1, 1, 0, 0, 1, 0, 1, '0, 8'hA2);
    edge_in(1, 1, 0, 0, 1, 0, 1, '0, 8'hA3);
    idle_edge();
  endtask

  task automatic t_burst_read();
    ctrl_read(4'h6);
    expect_out("R2 captured read", 1, 1, 8'hA2);
    edge_in(1, 1, 0, 1, 0, 1, 0, '0, '0);
    expect_out("R6 step to 7", 1, 1, 8'hA3);
    edge_in(1, 1, 0, 1, 0, 1, 0, '0, '0);
    expect_out("R6 wrap 7 to 4", 1, 1, 8'hA0);
    edge_in(1, 1, 1, 1, 0, 1, 0, '0, '0);
    expect_out("R7 hold repeats", 1, 1, 8'hA0);
    edge_in(1, 1, 0, 1, 0, 1, 0, '0, '0);
    expect_out("R4 burst write landed at 5", 1, 1, 8'hA1);
  endtask

  task automatic t_proc_strobe();
    edge_in(0, 1, 1, 0, 0, 1, 1, 4'h5, 8'h99);
    expect_out("R3 R10 proc strobe read with wr low", 1, 1, 8'hA1);
    edge_in(0, 0, 1, 0, 0, 1, 1, 4'h9, 8'h11);
    expect_out("R3 both strobes still read", 1, 1, 8'h66);
    ctrl_read(4'h5);
    expect_out("R3 word 5 unchanged", 1, 1, 8'hA1);
  endtask

  task automatic t_oe();
    edge_in(1, 0, 1, 1, 0, 1, 1, 4'h4, '0);
    expect_out("R9 oe high suppresses drive", 1, 0, '0);
    edge_in(1, 1, 1, 1, 0, 1, 0, '0, '0);
    expect_out("R9 oe low drives", 1, 1, 8'hA0);
  endtask

  task automatic t_deselect();
    ctrl_read(4'h8);
    expect_out("R2 read 8", 1, 1, 8'h55);
    edge_in(1, 0, 1, 1, 1, 1, 0, 4'h9, '0);
    expect_out("R5 sel_lo_n high deselects", 0, 0, '0);
    edge_in(1, 1, 0, 0, 0, 1, 0, '0, 8'h77);
    expect_out("R8 step write after deselect", 0, 0, '0);
    edge_in(1, 1, 1, 0, 0, 1, 0, '0, 8'h78);
    expect_out("R8 hold write after deselect", 0, 0, '0);
    ctrl_read(4'h9);
    expect_out("R8 word 9 unchanged", 1, 1, 8'h66);
    ctrl_read(4'h8);
    expect_out("R8 word 8 unchanged", 1, 1, 8'h55);
    edge_in(0, 1, 1, 1, 0, 0, 0, 4'hC, '0);
    expect_out("R5 sel_hi low deselects", 0, 0, '0);
    edge_in(1, 1, 0, 1, 0, 1, 0, '0, '0);
    expect_out("R8 step after proc deselect", 0, 0, '0);
  endtask

  task automatic t_select_ignored();
    ctrl_read(4'hC);
    expect_out("R2 read C", 1, 1, 8'h31);
    edge_in(1, 1, 0, 1, 1, 0, 0, '0, '0);
    expect_out("R11 step with selects off", 1, 1, 8'h32);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fill();
    t_burst_read();
    t_proc_strobe();
    t_oe();
    t_deselect();
    t_select_ignored();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule